// File: doc/BRIEF.md
# Key-Protected Slow Clock Source Selector

This block chooses where the slow timekeeping tick comes from. One source is an internal fast RC oscillator whose strobe is thinned by a programmable divider. The other is an external 32 kHz crystal strobe, which passes through without division. Both sources arrive as single-cycle enable strobes in one system clock domain. The block produces a selected slow tick as an enable strobe. It can also copy that tick to an output pin under a gate bit.

Software talks to the block over a simple 32-bit register bus. A write takes effect on the clock edge at which `bus_we` is high. Reads are combinational from `bus_addr`. Three registers are mapped:
- The control register, at offset 0x00, holds the source select.
- The prescaler register, at offset 0x08, holds the divide value.
- The gate register, at offset 0x60, holds the pin gate.

A change of source is guarded. A control write only applies when the upper half of the written word holds the unlock key 0x16AA. Whenever the source or the divide value changes, the divider restarts from zero.

Top module: `slowclk_sel`

## Requirements
- R1: After reset, the internal source is selected, the prescaler is 0, the pin gate is off, and all three mapped registers read 0.
- R2: A write to offset 0x00 with bits 31:16 equal to 0x16AA loads bit 0 into the source select, where 1 selects the external crystal and 0 selects the internal oscillator.
- R3: A write to offset 0x00 whose bits 31:16 differ from 0x16AA leaves the source select unchanged.
- R4: Reading offset 0x00 returns the source select in bit 0 and zero in every other bit, including the key field.
- R5: A write to offset 0x08 stores bits 4:0 as the divide value N. Reading offset 0x08 returns N in bits 4:0 and zero elsewhere.
- R6: With the internal source selected, each internal strobe advances a count. The strobe that finds the count equal to N wraps the count to 0 and makes `slow_tick` high in the following cycle. The result is one slow tick per N+1 internal strobes.
- R7: With the external source selected, `slow_tick` equals the external strobe of the previous cycle, and internal strobes have no effect.
- R8: Bit 0 of offset 0x60 is the pin gate and reads back in bit 0. `pin_tick` equals `slow_tick` while the gate is set and is 0 while it is clear.
- R9: A bus write that changes the source select or the divide value clears the count and suppresses `slow_tick` in the following cycle.
- R10: Reads of any other offset return 0. Writes to any other offset change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| rc_tick | input | 1 | Internal oscillator strobe |
| xt_tick | input | 1 | External crystal strobe |
| slow_tick | output | 1 | Selected slow tick strobe |
| pin_tick | output | 1 | Gated copy of slow_tick for the pin |

## Verification
The hardest situation to reach is a restart that lands exactly when the count has reached N and an internal strobe is present. In that cycle the restart must win over the wrap tick. Random stimulus rarely lines these up, so the prescaler writes are biased toward small values and the strobes are dense. Directed sequences also rewrite the prescaler in the middle of a count, and flip the source with the correct key while strobes are arriving. Wrong-key writes and writes to unmapped offsets are mixed into the random stream, and each one is followed by read-backs.

// File: rtl/slowclk_pkg.sv
package slowclk_pkg;
  // True when the upper half of a written word carries the unlock key.
  function automatic logic key_match(input logic [31:0] wd, input logic [15:0] key);
    return wd[31:16] == key;
  endfunction

  // True when the current internal strobe closes a divide period.
  function automatic logic div_wrap(input logic [7:0] cnt, input logic [7:0] n);
    return cnt == n;
  endfunction
endpackage

// File: rtl/slowclk_regs.sv
module slowclk_regs
  import slowclk_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          DIV_W    = 5,
  parameter logic [15:0] KEY      = 16'h16AA,
  parameter logic [7:0]  CTRL_OFS = 8'h00,
  parameter logic [7:0]  PRE_OFS  = 8'h08,
  parameter logic [7:0]  GATE_OFS = 8'h60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sel_ext,
  output logic [DIV_W-1:0]  presc,
  output logic              gate_en,
  output logic              restart
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_PRE  = ADDR_W'(PRE_OFS);
  localparam logic [ADDR_W-1:0] A_GATE = ADDR_W'(GATE_OFS);

  logic ctrl_wr, pre_wr, gate_wr, sel_change, pre_change;

  assign ctrl_wr    = bus_we && (bus_addr == A_CTRL);
  assign pre_wr     = bus_we && (bus_addr == A_PRE);
  assign gate_wr    = bus_we && (bus_addr == A_GATE);
  assign sel_change = ctrl_wr && key_match(bus_wdata, KEY) && (bus_wdata[0] != sel_ext);
  assign pre_change = pre_wr && (bus_wdata[DIV_W-1:0] != presc);
  assign restart    = sel_change || pre_change;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_ext <= 1'b0;
      presc   <= '0;
      gate_en <= 1'b0;
    end else begin
      if (sel_change) sel_ext <= bus_wdata[0];
      if (pre_wr)     presc   <= bus_wdata[DIV_W-1:0];
      if (gate_wr)    gate_en <= bus_wdata[0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL)      bus_rdata[0]         = sel_ext;
    else if (bus_addr == A_PRE)  bus_rdata[DIV_W-1:0] = presc;
    else if (bus_addr == A_GATE) bus_rdata[0]         = gate_en;
  end
endmodule

// File: rtl/slowclk_div.sv
module slowclk_div
  import slowclk_pkg::*;
#(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_ext,
  input  logic [DIV_W-1:0] presc,
  input  logic             restart,
  input  logic             rc_tick,
  input  logic             xt_tick,
  output logic [DIV_W-1:0] cnt,
  output logic             slow_tick
);
  logic wrap_now;
  assign wrap_now = div_wrap(8'(cnt), 8'(presc));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      slow_tick <= 1'b0;
    end else if (restart) begin
      cnt       <= '0;
      slow_tick <= 1'b0;
    end else if (sel_ext) begin
      slow_tick <= xt_tick;
    end else if (rc_tick) begin
      cnt       <= wrap_now ? '0 : cnt + 1'b1;
      slow_tick <= wrap_now;
    end else begin
      slow_tick <= 1'b0;
    end
  end
endmodule

// File: rtl/slowclk_sel.sv
module slowclk_sel #(
  parameter int          ADDR_W   = 8,
  parameter int          DIV_W    = 5,
  parameter logic [15:0] KEY      = 16'h16AA,
  parameter logic [7:0]  CTRL_OFS = 8'h00,
  parameter logic [7:0]  PRE_OFS  = 8'h08,
  parameter logic [7:0]  GATE_OFS = 8'h60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rc_tick,
  input  logic              xt_tick,
  output logic              slow_tick,
  output logic              pin_tick
);
  logic             sel_ext, gate_en, restart;
  logic [DIV_W-1:0] presc, div_cnt;

  slowclk_regs #(
    .ADDR_W(ADDR_W), .DIV_W(DIV_W), .KEY(KEY),
    .CTRL_OFS(CTRL_OFS), .PRE_OFS(PRE_OFS), .GATE_OFS(GATE_OFS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sel_ext(sel_ext),
    .presc(presc), .gate_en(gate_en), .restart(restart)
  );

  slowclk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .sel_ext(sel_ext), .presc(presc),
    .restart(restart), .rc_tick(rc_tick), .xt_tick(xt_tick),
    .cnt(div_cnt), .slow_tick(slow_tick)
  );

  assign pin_tick = slow_tick & gate_en;
endmodule

// File: rtl/slowclk_sva.sv
module slowclk_sva #(
  parameter int          ADDR_W   = 8,
  parameter int          DIV_W    = 5,
  parameter logic [15:0] KEY      = 16'h16AA,
  parameter logic [7:0]  CTRL_OFS = 8'h00
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              rc_tick,
  input logic              xt_tick,
  input logic              slow_tick,
  input logic              sel_ext,
  input logic              restart,
  input logic [DIV_W-1:0]  presc,
  input logic [DIV_W-1:0]  div_cnt
);
  assert_bad_key_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(CTRL_OFS) && bus_wdata[31:16] != KEY) |=> $stable(sel_ext));

  assert_restart_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!slow_tick && div_cnt == '0));

  assert_ext_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ext && !restart) |=> (slow_tick == $past(xt_tick)));

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt <= presc);

  assert_no_early_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_ext && !restart && rc_tick && div_cnt != presc) |=> !slow_tick);
endmodule

bind slowclk_sel slowclk_sva #(
  .ADDR_W(ADDR_W), .DIV_W(DIV_W), .KEY(KEY), .CTRL_OFS(CTRL_OFS)
) u_sva (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .rc_tick(rc_tick), .xt_tick(xt_tick),
  .slow_tick(slow_tick), .sel_ext(sel_ext), .restart(restart),
  .presc(presc), .div_cnt(div_cnt)
);

// File: tb/test_slowclk_sel.sv
`timescale 1ns/1ps
module test_slowclk_sel;
  logic        clk = 0, rst_n = 0;
  logic        bus_we = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        rc_tick = 0, xt_tick = 0;
  logic        slow_tick, pin_tick;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Reference state kept by the bench.
  bit m_sel = 0, m_gate = 0, m_tick = 0;
  int m_n = 0, m_cnt = 0;

  always #10 clk = ~clk;

  slowclk_sel i_slowclk_sel (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rc_tick(rc_tick),
    .xt_tick(xt_tick), .slow_tick(slow_tick), .pin_tick(pin_tick)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    if (a == 8'h00) return {31'b0, m_sel};
    if (a == 8'h08) return 32'(m_n);
    if (a == 8'h60) return {31'b0, m_gate};
    return 32'h0;
  endfunction

  function automatic string rd_tag(input logic [7:0] a);
    if (a == 8'h00) return "R4";
    if (a == 8'h08) return "R5";
    if (a == 8'h60) return "R8";
    return "R10";
  endfunction

  // One cycle: drive at negedge, model the edge, compare at next negedge.
  task automatic step(input bit we, input logic [7:0] a, input logic [31:0] wd,
                      input bit rc, input bit xt);
    bit rst_ev;
    string tg;
    bus_we = we; bus_addr = a; bus_wdata = wd; rc_tick = rc; xt_tick = xt;
    #1;
    if (!we) chk(rd_tag(a), bus_rdata, exp_read(a));
    rst_ev = (we && a == 8'h00 && wd[31:16] == 16'h16AA && wd[0] != m_sel) ||
             (we && a == 8'h08 && int'(wd[4:0]) != m_n);
    tg = rst_ev ? "R9" : (m_sel ? "R7" : "R6");
    if (rst_ev) begin m_cnt = 0; m_tick = 0; end
    else if (m_sel) m_tick = xt;
    else if (rc) begin
      if (m_cnt == m_n) begin m_cnt = 0; m_tick = 1; end
      else begin m_cnt++; m_tick = 0; end
    end else m_tick = 0;
    if (we && a == 8'h00 && wd[31:16] == 16'h16AA) m_sel = wd[0];
    if (we && a == 8'h08) m_n = int'(wd[4:0]);
    if (we && a == 8'h60) m_gate = wd[0];
    @(posedge clk);
    @(negedge clk);
    chk(tg, {31'b0, slow_tick}, {31'b0, m_tick});
    chk("R8", {31'b0, pin_tick}, {31'b0, m_tick & m_gate});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", bus_rdata, 32'h0);
    bus_addr = 8'h08; #1 chk("R1", bus_rdata, 32'h0);
    bus_addr = 8'h60; #1 chk("R1", bus_rdata, 32'h0);
    chk("R1", {31'b0, slow_tick}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    // R3: wrong key leaves internal select
    step(1, 8'h00, 32'h16AB_0001, 0, 0);
    step(0, 8'h00, 0, 0, 0);
    chk("R3", bus_rdata, 32'h0);
    // R2: correct key, key field not read back
    step(1, 8'h00, 32'h16AA_FFFF, 0, 1);
    step(0, 8'h00, 0, 1, 1);
    chk("R2", bus_rdata, 32'h1);
    step(1, 8'h00, 32'h16AA_0000, 1, 0);
    // R6: divide by 3 with gate on
    step(1, 8'h60, 32'h1, 0, 0);
    step(1, 8'h08, 32'hFFFF_FFE2, 0, 0);
    for (int i = 0; i < 10; i++) step(0, 8'h08, 0, 1, 0);
    // R9: prescaler change mid-count, and same-value rewrite (no restart)
    step(0, 8'h08, 0, 1, 0);
    step(1, 8'h08, 32'h4, 1, 0);
    step(1, 8'h08, 32'h4, 1, 0);
    for (int i = 0; i < 6; i++) step(0, 8'h00, 0, 1, 1);
    // R10: unmapped write changes nothing
    step(1, 8'h04, 32'hFFFF_FFFF, 0, 0);
    step(1, 8'h40, 32'h16AA_0001, 0, 0);
    step(0, 8'h00, 0, 0, 0);
    step(0, 8'h60, 0, 0, 0);
    // Constrained random mix
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom % 16);
      bit rc = ($urandom % 4) != 0;
      bit xt = ($urandom % 3) == 0;
      logic [31:0] rw = $urandom;
      case (r)
        0, 1: step(1, 8'h00, {16'h16AA, rw[15:0]}, rc, xt);
        2:    step(1, 8'h00, {rw[31:16] ^ 16'h0001 ^ 16'h16AA, rw[15:0]}, rc, xt);
        3:    step(1, 8'h08, {rw[31:3], 3'(rw[2:0] % 4)}, rc, xt);
        4:    step(1, 8'h08, rw, rc, xt);
        5:    step(1, 8'h60, rw, rc, xt);
        6:    step(1, 8'(rw[7:0] | 8'h01), rw, rc, xt);
        7:    step(0, rw[15:8], 0, rc, xt);
        8:    step(0, 8'h08, 0, rc, xt);
        9:    step(0, 8'h60, 0, rc, xt);
        default: step(0, 8'h00, 0, rc, xt);
      endcase
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule